// File: doc/BRIEF.md
# USB OUT Endpoint Receive FIFO with Transaction Commit

This block buffers the payload of OUT transactions for one endpoint of a USB function controller. The packet engine pulses a start strobe, streams the received bytes in, and then either pulses a close strobe once the transaction has ended well, or an abort strobe when it failed (bad CRC, NAK). Bytes that belong to a transaction still in flight are stored but kept out of sight of the reader. Only when the close strobe arrives does the whole group of bytes join the readable level, all in the same cycle.

Readable data leaves through one of two paths that share a single read pointer. One is a streaming port with a request/acknowledge handshake: the request is raised while committed bytes remain. The other is a pop strobe for a processor. A configuration input selects which path is live. The free-space figure counts uncommitted bytes as used. A flag tells the packet engine whether a whole maximum-size packet still fits, so that it can NAK when it does not.

Top module: `usb_rx_commit_fifo`

## Requirements
- R1: After reset, valid_count is 0, free_count equals DEPTH, port_req is low and pkt_room is high.
- R2: Bytes accepted while a transaction is open raise neither valid_count nor port_req before that transaction closes, even when the full packet has arrived.
- R3: One cycle after txn_close, valid_count has grown by the number of bytes accepted in that transaction, and port_req is high.
- R4: In port mode (cfg_cpu_mode = 0), port_req is high exactly when valid_count is non-zero. An edge with port_req and port_ack both high removes one byte. port_data always shows the oldest committed byte, so bytes leave in the order they were written.
- R5: port_ack while valid_count is 0 changes neither valid_count nor free_count.
- R6: The port can drain committed bytes while a later transaction is writing. When the committed bytes run out, port_req drops even though uncommitted bytes are stored. It rises again one cycle after that transaction closes.
- R7: A transaction accepts at most MAX_PKT bytes. Further bytes in the same transaction are discarded.
- R8: txn_abort during an open transaction discards every byte of that transaction. One cycle later, free_count equals DEPTH minus valid_count.
- R9: free_count equals DEPTH minus all stored bytes, whether committed or not. pkt_room is high exactly when free_count is at least MAX_PKT.
- R10: With cfg_cpu_mode = 1, port_req stays low and port_ack has no effect. cpu_rd removes one committed byte, and cpu_data shows the oldest committed byte.
- R11: wr_valid is ignored when no transaction is open, and when the FIFO is full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_cpu_mode | input | 1 | 1 selects the processor read path, 0 selects the streaming port |
| txn_open | input | 1 | Strobe: an OUT transaction starts |
| txn_close | input | 1 | Strobe: the open transaction ended well, commit its bytes |
| txn_abort | input | 1 | Strobe: the open transaction failed, discard its bytes |
| wr_valid | input | 1 | A received byte is present on wr_data |
| wr_data | input | DATA_W | Received byte |
| pkt_room | output | 1 | At least MAX_PKT bytes are free |
| free_count | output | $clog2(DEPTH)+1 | Free entries; uncommitted bytes count as used |
| valid_count | output | $clog2(DEPTH)+1 | Committed bytes not yet read |
| port_req | output | 1 | Streaming port request: committed data available |
| port_ack | input | 1 | Streaming port takes port_data |
| port_data | output | DATA_W | Oldest committed byte |
| cpu_rd | input | 1 | Processor pop strobe |
| cpu_data | output | DATA_W | Oldest committed byte, processor view |

## Verification
The hardest situation to reach is a drain that overtakes an unfinished transaction. The port must empty the committed region while uncommitted bytes sit right behind it, and then it must stall. The bench reaches this by committing a short packet and then opening a second transaction. It writes the second packet's bytes in the same cycles as it acknowledges the first packet's bytes. After the last committed byte has left, it checks that the request is low and that the free count still reflects the pending bytes. Only then does it close the transaction. The full case uses the same staging: it commits packets until no room is left, and then offers one more byte inside a fresh transaction.

// File: rtl/usb_rxf_pkg.sv
package usb_rxf_pkg;

   typedef enum logic {
      TXN_IDLE = 1'b0,
      TXN_OPEN = 1'b1
   } txn_state_e;

endpackage

// File: rtl/rxf_storage.sv
module rxf_storage #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_idx,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem_q[wr_idx] <= wr_data;
      end
   end

   // show-ahead head
   assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/rxf_write_ctrl.sv
module rxf_write_ctrl
   import usb_rxf_pkg::*;
#(
   parameter int DEPTH   = 64,
   parameter int MAX_PKT = 16,
   localparam int PW     = $clog2(DEPTH) + 1,
   localparam int CW     = $clog2(MAX_PKT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          txn_open,
   input  logic          txn_close,
   input  logic          txn_abort,
   input  logic          wr_valid,
   input  logic [PW-1:0] rd_ptr,
   output logic [PW-1:0] wr_ptr,
   output logic [PW-1:0] commit_ptr,
   output logic          wr_en
);

   txn_state_e    state_q;
   logic [CW-1:0] pkt_cnt_q;
   logic [PW-1:0] wr_ptr_q;
   logic [PW-1:0] commit_q;
   logic [PW-1:0] used;
   logic [PW-1:0] wr_ptr_nxt;
   logic          full;
   logic          in_txn;
   logic          accept;

   assign in_txn     = (state_q == TXN_OPEN);
   assign used       = wr_ptr_q - rd_ptr;
   assign full       = (used == PW'(DEPTH));
   assign accept     = in_txn && wr_valid && !full && !txn_abort
                       && (pkt_cnt_q < CW'(MAX_PKT));
   assign wr_ptr_nxt = wr_ptr_q + PW'(accept);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= TXN_IDLE;
         pkt_cnt_q <= '0;
         wr_ptr_q  <= '0;
         commit_q  <= '0;
      end else if (in_txn && txn_abort) begin
         // rewind to last commit point
         wr_ptr_q  <= commit_q;
         state_q   <= TXN_IDLE;
         pkt_cnt_q <= '0;
      end else begin
         wr_ptr_q <= wr_ptr_nxt;
         if (in_txn && txn_close) begin
            commit_q  <= wr_ptr_nxt;
            state_q   <= TXN_IDLE;
            pkt_cnt_q <= '0;
         end else if (!in_txn && txn_open) begin
            state_q   <= TXN_OPEN;
            pkt_cnt_q <= '0;
         end else if (accept) begin
            pkt_cnt_q <= pkt_cnt_q + CW'(1);
         end
      end
   end

   assign wr_ptr     = wr_ptr_q;
   assign commit_ptr = commit_q;
   assign wr_en      = accept;

endmodule

// File: rtl/rxf_read_ctrl.sv
module rxf_read_ctrl #(
   parameter int DEPTH       = 64,
   parameter bit CPU_PATH_EN = 1'b1,
   localparam int PW         = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_cpu_mode,
   input  logic          port_ack,
   input  logic          cpu_rd,
   input  logic [PW-1:0] commit_ptr,
   output logic [PW-1:0] rd_ptr,
   output logic          port_req,
   output logic          cpu_live
);

   logic [PW-1:0] rd_ptr_q;
   logic          has_valid;
   logic          port_pop;
   logic          cpu_pop;

   assign has_valid = (commit_ptr != rd_ptr_q);
   assign port_req  = has_valid && !cfg_cpu_mode;
   assign port_pop  = port_req && port_ack;

   generate
      if (CPU_PATH_EN) begin : g_cpu_path
         assign cpu_live = cfg_cpu_mode;
         assign cpu_pop  = cfg_cpu_mode && has_valid && cpu_rd;
      end else begin : g_no_cpu_path
         assign cpu_live = 1'b0;
         assign cpu_pop  = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr_q <= '0;
      end else if (port_pop || cpu_pop) begin
         rd_ptr_q <= rd_ptr_q + PW'(1);
      end
   end

   assign rd_ptr = rd_ptr_q;

endmodule

// File: rtl/usb_rx_commit_fifo.sv
module usb_rx_commit_fifo #(
   parameter int DATA_W      = 8,
   parameter int DEPTH       = 64,
   parameter int MAX_PKT     = 16,
   parameter bit CPU_PATH_EN = 1'b1,
   localparam int AW         = $clog2(DEPTH),
   localparam int PW         = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_cpu_mode,
   input  logic              txn_open,
   input  logic              txn_close,
   input  logic              txn_abort,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   output logic              pkt_room,
   output logic [PW-1:0]     free_count,
   output logic [PW-1:0]     valid_count,
   output logic              port_req,
   input  logic              port_ack,
   output logic [DATA_W-1:0] port_data,
   input  logic              cpu_rd,
   output logic [DATA_W-1:0] cpu_data
);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $fatal(1, "DEPTH must be a power of two, at least 2");
      end
      if (MAX_PKT < 1 || MAX_PKT > DEPTH) begin : g_bad_pkt
         $fatal(1, "MAX_PKT must lie in 1..DEPTH");
      end
      if (DATA_W < 1) begin : g_bad_width
         $fatal(1, "DATA_W must be positive");
      end
   endgenerate

   logic [PW-1:0]     wr_ptr;
   logic [PW-1:0]     commit_ptr;
   logic [PW-1:0]     rd_ptr;
   logic              wr_en;
   logic              cpu_live;
   logic [DATA_W-1:0] head_data;

   rxf_write_ctrl #(
      .DEPTH   (DEPTH),
      .MAX_PKT (MAX_PKT)
   ) u_wr (
      .clk        (clk),
      .rst_n      (rst_n),
      .txn_open   (txn_open),
      .txn_close  (txn_close),
      .txn_abort  (txn_abort),
      .wr_valid   (wr_valid),
      .rd_ptr     (rd_ptr),
      .wr_ptr     (wr_ptr),
      .commit_ptr (commit_ptr),
      .wr_en      (wr_en)
   );

   rxf_read_ctrl #(
      .DEPTH       (DEPTH),
      .CPU_PATH_EN (CPU_PATH_EN)
   ) u_rd (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_cpu_mode (cfg_cpu_mode),
      .port_ack     (port_ack),
      .cpu_rd       (cpu_rd),
      .commit_ptr   (commit_ptr),
      .rd_ptr       (rd_ptr),
      .port_req     (port_req),
      .cpu_live     (cpu_live)
   );

   rxf_storage #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_mem (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_idx  (wr_ptr[AW-1:0]),
      .wr_data (wr_data),
      .rd_idx  (rd_ptr[AW-1:0]),
      .rd_data (head_data)
   );

   // levels: uncommitted bytes occupy space but are not readable
   assign valid_count = commit_ptr - rd_ptr;
   assign free_count  = PW'(DEPTH) - (wr_ptr - rd_ptr);
   assign pkt_room    = (free_count >= PW'(MAX_PKT));

   assign port_data = head_data;
   assign cpu_data  = cpu_live ? head_data : '0;

endmodule

// File: rtl/usb_rx_commit_fifo_chk.sv
module usb_rx_commit_fifo_chk #(
   parameter int DATA_W  = 8,
   parameter int DEPTH   = 64,
   parameter int MAX_PKT = 16,
   localparam int PW     = $clog2(DEPTH) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_cpu_mode,
   input logic              txn_open,
   input logic              txn_close,
   input logic              txn_abort,
   input logic              wr_valid,
   input logic [DATA_W-1:0] wr_data,
   input logic              pkt_room,
   input logic [PW-1:0]     free_count,
   input logic [PW-1:0]     valid_count,
   input logic              port_req,
   input logic              port_ack,
   input logic [DATA_W-1:0] port_data,
   input logic              cpu_rd,
   input logic [DATA_W-1:0] cpu_data
);

   assert_open_write_hidden_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !txn_close && !port_ack && !cpu_rd)
      |=> valid_count == $past(valid_count));

   assert_port_pop_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (port_req && port_ack && !txn_close)
      |=> valid_count == $past(valid_count) - PW'(1));

   assert_empty_ack_noop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_count == '0 && !txn_close)
      |=> valid_count == '0);

   assert_abort_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      txn_abort |=> ({1'b0, free_count} + {1'b0, valid_count}) == (PW+1)'(DEPTH));

   assert_level_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, free_count} + {1'b0, valid_count}) <= (PW+1)'(DEPTH));

   assert_cpu_mode_ack_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_cpu_mode && port_ack && !cpu_rd && !txn_close)
      |=> valid_count == $past(valid_count));

endmodule

bind usb_rx_commit_fifo usb_rx_commit_fifo_chk #(
   .DATA_W  (DATA_W),
   .DEPTH   (DEPTH),
   .MAX_PKT (MAX_PKT)
) u_chk (.*);

// File: tb/usb_rx_commit_fifo_tb.sv
`timescale 1ns/1ps
module usb_rx_commit_fifo_tb;

   localparam int DW  = 8;
   localparam int DEP = 32;
   localparam int MP  = 8;
   localparam int PW  = $clog2(DEP) + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_cpu_mode = 1'b0;
   logic          txn_open = 1'b0;
   logic          txn_close = 1'b0;
   logic          txn_abort = 1'b0;
   logic          wr_valid = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          pkt_room;
   logic [PW-1:0] free_count;
   logic [PW-1:0] valid_count;
   logic          port_req;
   logic          port_ack = 1'b0;
   logic [DW-1:0] port_data;
   logic          cpu_rd = 1'b0;
   logic [DW-1:0] cpu_data;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   usb_rx_commit_fifo #(
      .DATA_W (DW),
      .DEPTH  (DEP),
      .MAX_PKT(MP)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_cpu_mode(cfg_cpu_mode),
      .txn_open(txn_open), .txn_close(txn_close), .txn_abort(txn_abort),
      .wr_valid(wr_valid), .wr_data(wr_data), .pkt_room(pkt_room),
      .free_count(free_count), .valid_count(valid_count),
      .port_req(port_req), .port_ack(port_ack), .port_data(port_data),
      .cpu_rd(cpu_rd), .cpu_data(cpu_data)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // one clock edge; inputs set before, sampled 1ns after
   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic open_txn();
      txn_open = 1'b1; step(); txn_open = 1'b0;
   endtask

   task automatic close_txn();
      txn_close = 1'b1; step(); txn_close = 1'b0;
   endtask

   task automatic put(input logic [DW-1:0] d);
      wr_valid = 1'b1; wr_data = d; step(); wr_valid = 1'b0;
   endtask

   task automatic pop_port(input string req, input logic [DW-1:0] exp);
      chk(req, "port_req before pop", int'(port_req), 1);
      chk(req, "port_data", int'(port_data), int'(exp));
      port_ack = 1'b1; step(); port_ack = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "valid_count", int'(valid_count), 0);
      chk("R1", "free_count", int'(free_count), DEP);
      chk("R1", "port_req", int'(port_req), 0);
      chk("R1", "pkt_room", int'(pkt_room), 1);
   endtask

   task automatic t_commit_gate();
      open_txn();
      for (int i = 0; i < 5; i++) put(8'hA0 + 8'(i));
      chk("R2", "valid_count while open", int'(valid_count), 0);
      chk("R2", "port_req while open", int'(port_req), 0);
      chk("R9", "free_count counts pending", int'(free_count), DEP - 5);
      close_txn();
      chk("R3", "valid_count after close", int'(valid_count), 5);
      chk("R3", "port_req after close", int'(port_req), 1);
      for (int i = 0; i < 5; i++) pop_port("R4", 8'hA0 + 8'(i));
      chk("R4", "valid_count drained", int'(valid_count), 0);
      chk("R4", "port_req drained", int'(port_req), 0);
   endtask

   task automatic t_ack_empty();
      port_ack = 1'b1; step(); step(); port_ack = 1'b0;
      chk("R5", "valid_count", int'(valid_count), 0);
      chk("R5", "free_count", int'(free_count), DEP);
   endtask

   task automatic t_overlap();
      open_txn();
      for (int i = 0; i < 3; i++) put(8'hB0 + 8'(i));
      close_txn();
      open_txn();
      for (int i = 0; i < 3; i++) begin
         chk("R6", "port_data during write", int'(port_data), int'(8'hB0 + 8'(i)));
         wr_valid = 1'b1; wr_data = 8'hC0 + 8'(i); port_ack = 1'b1;
         step();
         wr_valid = 1'b0; port_ack = 1'b0;
      end
      chk("R6", "port_req stalls on pending", int'(port_req), 0);
      chk("R6", "valid_count stalls", int'(valid_count), 0);
      chk("R6", "free_count keeps pending", int'(free_count), DEP - 3);
      close_txn();
      chk("R6", "port_req resumes", int'(port_req), 1);
      chk("R6", "valid_count resumes", int'(valid_count), 3);
      for (int i = 0; i < 3; i++) pop_port("R6", 8'hC0 + 8'(i));
   endtask

   task automatic t_max_pkt();
      open_txn();
      for (int i = 0; i < MP + 3; i++) put(8'h10 + 8'(i));
      close_txn();
      chk("R7", "valid_count capped", int'(valid_count), MP);
      for (int i = 0; i < MP; i++) pop_port("R7", 8'h10 + 8'(i));
      chk("R7", "no extra bytes", int'(valid_count), 0);
   endtask

   task automatic t_abort();
      open_txn();
      for (int i = 0; i < 4; i++) put(8'hEE);
      txn_abort = 1'b1; step(); txn_abort = 1'b0;
      chk("R8", "free_count after abort", int'(free_count), DEP);
      chk("R8", "valid_count after abort", int'(valid_count), 0);
      open_txn();
      put(8'h5A);
      close_txn();
      chk("R8", "valid_count next txn", int'(valid_count), 1);
      pop_port("R8", 8'h5A);
   endtask

   task automatic t_full();
      put(8'h77);
      chk("R11", "idle write ignored", int'(free_count), DEP);
      for (int p = 0; p < DEP / MP; p++) begin
         open_txn();
         for (int i = 0; i < MP; i++) put(8'(p * MP + i));
         close_txn();
         if (p == DEP / MP - 2) begin
            chk("R9", "free_count one pkt left", int'(free_count), MP);
            chk("R9", "pkt_room one pkt left", int'(pkt_room), 1);
         end
      end
      chk("R9", "free_count full", int'(free_count), 0);
      chk("R9", "pkt_room full", int'(pkt_room), 0);
      open_txn();
      put(8'hFF);
      close_txn();
      chk("R11", "full write dropped", int'(valid_count), DEP);
      for (int i = 0; i < DEP; i++) pop_port("R11", 8'(i));
      chk("R11", "drained after full", int'(free_count), DEP);
   endtask

   task automatic t_cpu_mode();
      open_txn();
      for (int i = 0; i < 3; i++) put(8'h60 + 8'(i));
      close_txn();
      cfg_cpu_mode = 1'b1;
      #1;
      chk("R10", "port_req in cpu mode", int'(port_req), 0);
      port_ack = 1'b1; step(); port_ack = 1'b0;
      chk("R10", "port_ack ignored", int'(valid_count), 3);
      for (int i = 0; i < 3; i++) begin
         chk("R10", "cpu_data", int'(cpu_data), int'(8'h60 + 8'(i)));
         cpu_rd = 1'b1; step(); cpu_rd = 1'b0;
      end
      chk("R10", "cpu drained", int'(valid_count), 0);
      cfg_cpu_mode = 1'b0;
   endtask

   initial begin
      #1;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_commit_gate();
      t_ack_empty();
      t_overlap();
      t_max_pkt();
      t_abort();
      t_full();
      t_cpu_mode();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule